// File: doc/BRIEF.md
# Deadline Compare Timer Scheduler

This block keeps a never-wrapping microsecond time and drives a table of timed events from it. A prescaler divides the core clock down to a 1 MHz tick. A 16-bit counter runs free on that tick over its whole span. A wrap extender adds a base that grows by 65536 each time the sampled count falls below the value sampled one cycle earlier, so `now_o` is a 64-bit time that starts at 0 and only moves forward.

A host arms any of four slots by strobing `arm_i` with a slot index, a 64-bit deadline and a 64-bit repeat period. A deadline of 0 marks the slot idle. When the time reaches a pending deadline, the slot's bit of `fire_o` pulses for one clock. A slot with a nonzero period is then re-armed at its old deadline plus the period. A slot with a zero period drops back to idle.

A single 16-bit compare register follows the earliest pending deadline. Its value is clamped to lie at least a minimum lead time and at most a maximum horizon ahead of the present time. The compare therefore matches often enough that the time base is kept in step. `match_o` strobes when the counter lands on the compare value.

The scheduler is a three-state machine:
- **WATCH** is the reset state. It fires the lowest-numbered expired slot and moves to FIRE. With nothing expired and a reload pending, it moves to LOAD. Otherwise it stays in WATCH.
- **FIRE** fires the lowest-numbered expired slot and stays in FIRE while any slot has expired. When none has, it moves to LOAD.
- **LOAD** writes the new compare value and returns to WATCH.

A reload becomes pending on every arm strobe and on every compare match.

Top module: `deadline_cmp_sched`

## Requirements
- R1: The time advances by exactly 1 every CLK_MHZ clocks. CLK_MHZ must be a whole number of MHz greater than 1.
- R2: The 16-bit counter wraps after 0xFFFF. The extended time keeps counting through the wrap, so that 65535 is followed by 65536. A deadline beyond the wrap loads its low 16 bits into the compare and fires at the correct extended time.
- R3: After reset the time is 0, the compare register holds 1000, and `fire_o` and `match_o` are low.
- R4: `match_o` is high for exactly one clock: the first clock in which the counter equals the compare register. Each match causes a compare reload.
- R5: With no pending slot, or with the earliest pending deadline at or beyond now + 50000, the reloaded compare is the low 16 bits of now + 50000, where "now" is the time during the LOAD clock.
- R6: When the earliest pending deadline lies strictly between now + 50 and now + 50000, the compare is loaded with that deadline's low 16 bits. The earliest is taken over all pending slots.
- R7: When the earliest pending deadline is at or before now + 50, the compare is loaded with the low 16 bits of now + 50. Every loaded compare lies between 50 and 50000 ahead of the counter.
- R8: Bit i of `fire_o` pulses in the first clock in which the time equals slot i's deadline. A slot with period 0 then becomes idle and does not fire again.
- R9: A slot with a nonzero period P and deadline D fires at D, D+P, D+2P and so on.
- R10: Arming a slot that is already pending replaces its deadline and period. The old deadline never fires.
- R11: When several slots have expired at once, they fire in ascending index order, one slot per clock, in consecutive clocks.
- R12: Arming a slot with deadline 0 makes it idle. An idle slot never fires and is ignored when the compare target is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, CLK_MHZ MHz |
| rst_ni | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | One-clock strobe that writes a slot |
| arm_slot_i | input | 2 | Index of the slot to write |
| arm_deadline_i | input | 64 | Absolute deadline in µs; 0 means idle |
| arm_period_i | input | 64 | Repeat period in µs; 0 means one-shot |
| now_o | output | 64 | Extended microsecond time |
| cmp_o | output | 16 | Current compare register value |
| match_o | output | 1 | Compare-match strobe |
| fire_o | output | 4 | Per-slot expiry pulse; bit i is slot i |

## Verification
A fire pulse appears in the very clock in which `now_o` first equals the deadline, and `match_o` appears in the first clock of the matching count. The bench polls every clock while the time is still short of the target, so its first sample at the target value is the clock that must show the pulse.

A compare reload takes effect three clocks after the clock that carries the arm strobe: one clock to store the slot, one clock in WATCH, and one clock in LOAD. The bench records `now_o` during the LOAD clock and checks `cmp_o` one clock later. After a match, the same count gives LOAD two clocks after the match clock.

For simultaneous expiry, the bench samples three consecutive clocks and expects the slots in ascending order.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    // Scheduler states: watch for expiry, fire expired slots, reload compare
    typedef enum logic [1:0] {
        DCS_WATCH = 2'd0,
        DCS_FIRE  = 2'd1,
        DCS_LOAD  = 2'd2
    } dcs_state_e;

endpackage

// File: rtl/dcs_prescaler.sv
module dcs_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;
    logic          last_w;

    assign last_w = (pre_q == LAST);
    assign tick_o = last_w;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else if (last_w) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/dcs_time_extender.sv
module dcs_time_extender #(
    parameter int CW = 16,
    parameter int TW = 64
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    output logic [CW-1:0] cnt_o,
    output logic [TW-1:0] now_o
);
    localparam logic [TW-1:0] SPAN = TW'(1) << CW;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] prev_q;
    logic [TW-1:0] base_q;
    logic [TW-1:0] base_w;
    logic          wrapped_w;

    // A sampled count below the previous sample means one full span has passed
    assign wrapped_w = (cnt_q < prev_q);
    assign base_w    = wrapped_w ? (base_q + SPAN) : base_q;
    assign now_o     = base_w + TW'(cnt_q);
    assign cnt_o     = cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            prev_q <= '0;
            base_q <= '0;
        end else begin
            if (tick_i) begin
                cnt_q <= cnt_q + CW'(1);
            end
            prev_q <= cnt_q;
            base_q <= base_w;
        end
    end

    // R2
    now_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (now_o >= $past(now_o)));

endmodule

// File: rtl/dcs_slot_table.sv
module dcs_slot_table #(
    parameter int N  = 4,
    parameter int TW = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          arm_i,
    input  logic [IW-1:0] arm_idx_i,
    input  logic [TW-1:0] arm_dl_i,
    input  logic [TW-1:0] arm_per_i,
    input  logic          fire_i,
    input  logic [IW-1:0] fire_idx_i,
    input  logic [TW-1:0] now_i,
    output logic          exp_any_o,
    output logic [IW-1:0] exp_idx_o,
    output logic          pend_any_o,
    output logic [TW-1:0] earliest_o
);
    logic [TW-1:0] dl_q  [N];
    logic [TW-1:0] per_q [N];
    logic [N-1:0]  expired_w;

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic hit_arm;
        logic hit_fire;

        assign hit_arm      = arm_i  && (arm_idx_i  == IW'(i));
        assign hit_fire     = fire_i && (fire_idx_i == IW'(i));
        assign expired_w[i] = (dl_q[i] != '0) && (dl_q[i] <= now_i);

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                dl_q[i]  <= '0;
                per_q[i] <= '0;
            end else if (hit_arm) begin
                // host write wins over a same-clock expiry update
                dl_q[i]  <= arm_dl_i;
                per_q[i] <= arm_per_i;
            end else if (hit_fire) begin
                if (per_q[i] != '0) begin
                    dl_q[i] <= dl_q[i] + per_q[i];
                end else begin
                    dl_q[i] <= '0;
                end
            end
        end

        // R8
        oneshot_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hit_fire && !hit_arm && (per_q[i] == '0)) |=> (dl_q[i] == '0));

        // R9
        periodic_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hit_fire && !hit_arm && (per_q[i] != '0))
            |=> (dl_q[i] == ($past(dl_q[i]) + $past(per_q[i]))));
    end

    // Lowest expired index wins
    always_comb begin
        exp_any_o = |expired_w;
        exp_idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (expired_w[i]) begin
                exp_idx_o = IW'(i);
            end
        end
    end

    // Earliest pending deadline over all non-idle slots
    always_comb begin
        pend_any_o = 1'b0;
        earliest_o = '0;
        for (int i = 0; i < N; i++) begin
            if ((dl_q[i] != '0) && (!pend_any_o || (dl_q[i] < earliest_o))) begin
                earliest_o = dl_q[i];
                pend_any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dcs_target_pick.sv
module dcs_target_pick #(
    parameter int TW      = 64,
    parameter int CW      = 16,
    parameter int LEAD    = 50,
    parameter int HORIZON = 50000
) (
    input  logic [TW-1:0] now_i,
    input  logic          pend_i,
    input  logic [TW-1:0] earliest_i,
    output logic [CW-1:0] target_o
);
    logic [TW-1:0] lead_w;
    logic [TW-1:0] far_w;

    assign lead_w = now_i + TW'(LEAD);
    assign far_w  = now_i + TW'(HORIZON);

    always_comb begin
        if (pend_i && (earliest_i <= lead_w)) begin
            target_o = lead_w[CW-1:0];
        end else if (pend_i && (earliest_i < far_w)) begin
            target_o = earliest_i[CW-1:0];
        end else begin
            target_o = far_w[CW-1:0];
        end
    end

endmodule

// File: rtl/deadline_cmp_sched.sv
module deadline_cmp_sched #(
    parameter int CLK_MHZ    = 8,
    parameter int NUM_SLOTS  = 4,
    parameter int TW         = 64,
    parameter int CW         = 16,
    parameter int LEAD_US    = 50,
    parameter int HORIZON_US = 50000,
    parameter int CMP_RESET  = 1000,
    localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 arm_i,
    input  logic [IW-1:0]        arm_slot_i,
    input  logic [TW-1:0]        arm_deadline_i,
    input  logic [TW-1:0]        arm_period_i,
    output logic [TW-1:0]        now_o,
    output logic [CW-1:0]        cmp_o,
    output logic                 match_o,
    output logic [NUM_SLOTS-1:0] fire_o
);
    import dcs_pkg::*;

    dcs_state_e    st_q, st_d;
    logic          tick_w;
    logic [CW-1:0] cnt_w;
    logic [TW-1:0] now_w;
    logic          exp_any_w;
    logic [IW-1:0] exp_idx_w;
    logic          pend_w;
    logic [TW-1:0] earliest_w;
    logic [CW-1:0] target_w;
    logic [CW-1:0] cmp_q;
    logic          fresh_q;
    logic          resched_q;
    logic          fire_en_w;
    logic          load_en_w;
    logic          match_w;

    dcs_prescaler #(.DIV(CLK_MHZ)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick_w)
    );

    dcs_time_extender #(.CW(CW), .TW(TW)) u_ext (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_w),
        .cnt_o  (cnt_w),
        .now_o  (now_w)
    );

    dcs_slot_table #(.N(NUM_SLOTS), .TW(TW)) u_slots (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .arm_i      (arm_i),
        .arm_idx_i  (arm_slot_i),
        .arm_dl_i   (arm_deadline_i),
        .arm_per_i  (arm_period_i),
        .fire_i     (fire_en_w),
        .fire_idx_i (exp_idx_w),
        .now_i      (now_w),
        .exp_any_o  (exp_any_w),
        .exp_idx_o  (exp_idx_w),
        .pend_any_o (pend_w),
        .earliest_o (earliest_w)
    );

    dcs_target_pick #(
        .TW(TW), .CW(CW), .LEAD(LEAD_US), .HORIZON(HORIZON_US)
    ) u_pick (
        .now_i      (now_w),
        .pend_i     (pend_w),
        .earliest_i (earliest_w),
        .target_o   (target_w)
    );

    // Counter just stepped onto the compare value
    assign match_w = fresh_q && (cnt_w == cmp_q);

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= DCS_WATCH;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DCS_WATCH: begin
                if (exp_any_w) begin
                    st_d = DCS_FIRE;
                end else if (resched_q) begin
                    st_d = DCS_LOAD;
                end
            end
            DCS_FIRE: begin
                if (!exp_any_w) begin
                    st_d = DCS_LOAD;
                end
            end
            DCS_LOAD: begin
                st_d = DCS_WATCH;
            end
            default: begin
                st_d = DCS_WATCH;
            end
        endcase
    end

    // State outputs
    always_comb begin
        fire_en_w = 1'b0;
        load_en_w = 1'b0;
        unique case (st_q)
            DCS_WATCH: fire_en_w = exp_any_w;
            DCS_FIRE:  fire_en_w = exp_any_w;
            DCS_LOAD:  load_en_w = 1'b1;
            default:   fire_en_w = 1'b0;
        endcase
        fire_o = fire_en_w ? (NUM_SLOTS'(1) << exp_idx_w) : '0;
    end

    // Compare register, reload request and tick history
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cmp_q     <= CW'(CMP_RESET);
            resched_q <= 1'b0;
            fresh_q   <= 1'b0;
        end else begin
            fresh_q <= tick_w;
            if (load_en_w) begin
                cmp_q <= target_w;
            end
            if (arm_i || match_w) begin
                resched_q <= 1'b1;
            end else if (load_en_w) begin
                resched_q <= 1'b0;
            end
        end
    end

    assign now_o   = now_w;
    assign cmp_o   = cmp_q;
    assign match_o = match_w;

    // R4
    match_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |=> !match_o);

    // R7
    cmp_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == DCS_LOAD) |=>
            ((CW'(cmp_q - $past(cnt_w)) >= CW'(LEAD_US)) &&
             (CW'(cmp_q - $past(cnt_w)) <= CW'(HORIZON_US))));

    // R11
    fire_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(fire_o));

endmodule

// File: tb/tb_deadline_cmp_sched.sv
module tb_deadline_cmp_sched;

    logic        clk = 1'b0;
    logic        rst_ni;
    logic        arm_i;
    logic [1:0]  arm_slot_i;
    logic [63:0] arm_deadline_i;
    logic [63:0] arm_period_i;
    logic [63:0] now_o;
    logic [15:0] cmp_o;
    logic        match_o;
    logic [3:0]  fire_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    deadline_cmp_sched #(.CLK_MHZ(2)) dut (
        .clk_i          (clk),
        .rst_ni         (rst_ni),
        .arm_i          (arm_i),
        .arm_slot_i     (arm_slot_i),
        .arm_deadline_i (arm_deadline_i),
        .arm_period_i   (arm_period_i),
        .now_o          (now_o),
        .cmp_o          (cmp_o),
        .match_o        (match_o),
        .fire_o         (fire_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic arm(input int idx, input logic [63:0] dl, input logic [63:0] per);
        @(negedge clk);
        arm_i          = 1'b1;
        arm_slot_i     = 2'(idx);
        arm_deadline_i = dl;
        arm_period_i   = per;
        @(negedge clk);
        arm_i = 1'b0;
    endtask

    // Arm, then capture the time seen in the LOAD clock; returns one clock after LOAD
    task automatic arm_load(input int idx, input logic [63:0] dl, input logic [63:0] per,
                            output logic [63:0] nl);
        arm(idx, dl, per);
        @(negedge clk);
        nl = now_o;
        @(negedge clk);
    endtask

    task automatic wait_now(input logic [63:0] t);
        while (now_o < t) @(negedge clk);
    endtask

    task automatic wait_fire(output logic [3:0] fv, output logic [63:0] nv);
        @(negedge clk);
        while (fire_o == 4'b0) @(negedge clk);
        fv = fire_o;
        nv = now_o;
    endtask

    task automatic t_reset();
        chk(now_o == 64'd0, "R3 time after reset", now_o, 0);
        chk(cmp_o == 16'd1000, "R3 compare after reset", 64'(cmp_o), 1000);
        chk(fire_o == 4'b0, "R3 fire idle", 64'(fire_o), 0);
        chk(match_o == 1'b0, "R3 match idle", 64'(match_o), 0);
    endtask

    task automatic t_prescale();
        logic [63:0] v;
        int cyc;
        v = now_o;
        while (now_o == v) @(negedge clk);
        v   = now_o;
        cyc = 0;
        while (now_o == v) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 2, "R1 clocks per microsecond", 64'(cyc), 2);
        chk(now_o == v + 1, "R1 step size", now_o, v + 1);
    endtask

    task automatic t_first_match();
        logic [63:0] nl;
        wait_now(64'd1000);
        chk(match_o == 1'b1, "R4 match at reset compare", 64'(match_o), 1);
        @(negedge clk);
        chk(match_o == 1'b0, "R4 match one clock", 64'(match_o), 0);
        @(negedge clk);
        nl = now_o;
        @(negedge clk);
        chk(cmp_o == 16'(nl + 50000), "R5 reload to horizon after match", 64'(cmp_o),
            64'(16'(nl + 50000)));
    endtask

    task automatic t_horizon();
        logic [63:0] nl;
        arm_load(0, now_o + 100000, 0, nl);
        chk(cmp_o == 16'(nl + 50000), "R5 far deadline clamped to horizon", 64'(cmp_o),
            64'(16'(nl + 50000)));
        arm_load(0, 0, 0, nl);
    endtask

    task automatic t_window();
        logic [63:0] n;
        logic [63:0] nl;
        int extra;
        n = now_o;
        arm_load(1, n + 3000, 0, nl);
        chk(cmp_o == 16'(n + 3000), "R6 compare follows deadline", 64'(cmp_o),
            64'(16'(n + 3000)));
        arm_load(2, n + 2000, 0, nl);
        chk(cmp_o == 16'(n + 2000), "R6 compare follows earliest", 64'(cmp_o),
            64'(16'(n + 2000)));
        wait_now(n + 2000);
        chk(match_o == 1'b1, "R4 match at deadline", 64'(match_o), 1);
        chk(fire_o == 4'b0100, "R8 slot 2 fires at deadline", 64'(fire_o), 4);
        wait_now(n + 3000);
        chk(fire_o == 4'b0010, "R8 slot 1 fires at deadline", 64'(fire_o), 2);
        extra = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (fire_o != 4'b0) extra++;
        end
        chk(extra == 0, "R8 one-shot slots stay idle", 64'(extra), 0);
    endtask

    task automatic t_clamp();
        logic [63:0] n;
        logic [63:0] nl;
        n = now_o;
        arm_load(3, n + 10, 0, nl);
        chk(cmp_o == 16'(nl + 50), "R7 near deadline clamped to lead", 64'(cmp_o),
            64'(16'(nl + 50)));
        wait_now(n + 10);
        chk(fire_o == 4'b1000, "R8 slot 3 fires at near deadline", 64'(fire_o), 8);
    endtask

    task automatic t_replace();
        logic [63:0] n;
        int early;
        n = now_o;
        arm(0, n + 400, 0);
        arm(0, n + 900, 0);
        early = 0;
        while (now_o < n + 900) begin
            @(negedge clk);
            if (now_o < n + 900 && fire_o != 4'b0) early++;
        end
        chk(early == 0, "R10 replaced deadline does not fire", 64'(early), 0);
        chk(fire_o == 4'b0001, "R10 new deadline fires", 64'(fire_o), 1);
    endtask

    task automatic t_cancel();
        logic [63:0] n;
        logic [63:0] nl;
        int extra;
        n = now_o;
        arm_load(2, n + 2000, 0, nl);
        chk(cmp_o == 16'(n + 2000), "R6 pending slot sets compare", 64'(cmp_o),
            64'(16'(n + 2000)));
        arm_load(2, 0, 0, nl);
        chk(cmp_o == 16'(nl + 50000), "R12 idle slot ignored for compare", 64'(cmp_o),
            64'(16'(nl + 50000)));
        extra = 0;
        while (now_o < n + 2100) begin
            @(negedge clk);
            if (fire_o != 4'b0) extra++;
        end
        chk(extra == 0, "R12 cancelled slot never fires", 64'(extra), 0);
    endtask

    task automatic t_periodic();
        logic [63:0] n;
        logic [63:0] nv;
        logic [3:0]  fv;
        int extra;
        n = now_o;
        arm(1, n + 300, 250);
        wait_fire(fv, nv);
        chk(fv == 4'b0010 && nv == n + 300, "R9 first periodic fire", nv, n + 300);
        wait_fire(fv, nv);
        chk(fv == 4'b0010 && nv == n + 550, "R9 second periodic fire", nv, n + 550);
        wait_fire(fv, nv);
        chk(fv == 4'b0010 && nv == n + 800, "R9 third periodic fire", nv, n + 800);
        arm(1, 0, 0);
        extra = 0;
        while (now_o < n + 1200) begin
            @(negedge clk);
            if (fire_o != 4'b0) extra++;
        end
        chk(extra == 0, "R12 stopped periodic slot stays idle", 64'(extra), 0);
    endtask

    task automatic t_simul();
        logic [63:0] n;
        logic [63:0] nv;
        logic [3:0]  fv;
        n = now_o;
        arm(3, n + 200, 0);
        arm(1, n + 200, 0);
        arm(2, n + 200, 0);
        wait_fire(fv, nv);
        chk(fv == 4'b0010 && nv == n + 200, "R11 lowest slot first", 64'(fv), 2);
        @(negedge clk);
        chk(fire_o == 4'b0100, "R11 second slot next clock", 64'(fire_o), 4);
        @(negedge clk);
        chk(fire_o == 4'b1000, "R11 third slot next clock", 64'(fire_o), 8);
        @(negedge clk);
        chk(fire_o == 4'b0000, "R11 burst ends", 64'(fire_o), 0);
    endtask

    task automatic t_wrap();
        logic [63:0] nl;
        logic [63:0] prev;
        int back;
        wait_now(64'd65000);
        arm_load(0, 64'd65636, 0, nl);
        chk(cmp_o == 16'd100, "R2 compare takes low bits past wrap", 64'(cmp_o), 100);
        back = 0;
        prev = now_o;
        while (now_o < 64'd65636) begin
            @(negedge clk);
            if (now_o < prev) back++;
            prev = now_o;
        end
        chk(back == 0, "R2 time never steps back", 64'(back), 0);
        chk(fire_o == 4'b0001, "R2 fire after wrap", 64'(fire_o), 1);
        chk(now_o[63:16] == 48'd1, "R2 extended upper bits", 64'(now_o[63:16]), 1);
        wait_now(64'd65800);
        chk(now_o == 64'd65800, "R2 extended time continues", now_o, 65800);
    endtask

    initial begin
        rst_ni         = 1'b0;
        arm_i          = 1'b0;
        arm_slot_i     = '0;
        arm_deadline_i = '0;
        arm_period_i   = '0;
        repeat (4) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_first_match();
        t_horizon();
        t_window();
        t_clamp();
        t_replace();
        t_cancel();
        t_periodic();
        t_simul();
        t_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule